// File: doc/BRIEF.md
# Transmit Inter-Frame Idle Controller

This block sits beside the transmit path of a four-lane, 32-bit-per-cycle 10G Ethernet datapath. When a frame finishes, it works out how many whole idle columns (one column is four octets, one per lane) must pass before the next frame may begin. It then raises a hold signal for exactly that many cycles. Framing, control-character coding and the data itself are handled elsewhere. This block sees only a frame-end strobe, the lane that carried the last data octet, and the frame's octet count.

A single 10-bit gap setting is read in one of two ways, chosen by a mode input. In LAN mode the setting is a target idle length in octets, in steps of four. Since every frame starts on lane 0, the spare lanes after the last data octet cannot always be padded exactly. A small deficit counter carries the rounding error from one frame to the next, so that over many frames the average gap equals the setting. In WAN mode the setting is a stretch factor. One idle octet is owed for every (factor+1)*8 octets sent, the remainder carries over to later frames, and the owed idle is rounded up to whole columns at each frame end. A larger factor therefore gives a shorter gap and more bandwidth.

Top module: `ipg_gap_ctrl`

## Requirements
- R1: After reset, hold is low, the LAN deficit and the WAN octet carry are both zero, and the stored gap setting is 12.
- R2: The gap setting is loaded from the 10-bit `cfg_gap` only in a cycle where `cfg_we` is high, and it takes effect for frames ending from the next cycle on. When `cfg_we` is low, `cfg_gap` has no effect.
- R3: In LAN mode the setting is clamped to the range 8..100 and then rounded down to a multiple of 4. This gives the effective gap G.
- R4: In LAN mode, with end lane e (0..3) and deficit d, let need = G - (3 - e), n = need div 4 and r = need mod 4. If d + r <= 3, the idle column count is n and the new deficit is d + r. Otherwise the count is n + 1 and the new deficit is d + r - 4.
- R5: The LAN deficit stays within 0..3 and changes only at a LAN frame end. Over a long run, the total idle octets (tail lanes plus 4 per column) stay within 3 octets of G times the number of frames.
- R6: In WAN mode the setting is clamped to the range 4..15, giving factor S, and the stretch ratio is Q = (S+1)*8 octets.
- R7: In WAN mode, at a frame end with octet count B and carry C, let T = C + B. The idle column count is ceil(floor(T/Q)/4), and the new carry is T mod Q.
- R8: Hold is high from the cycle after the frame-end strobe for exactly the computed number of columns, and it is low in the cycle after the last column. Hold never rises unless a frame end was strobed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the gap setting |
| cfg_gap | input | 10 | Gap setting: octets in LAN mode, stretch factor in WAN mode |
| wan_mode | input | 1 | 0 selects LAN mode, 1 selects WAN mode |
| frame_end | input | 1 | One-cycle strobe in the column that holds a frame's last data octet |
| end_lane | input | 2 | Lane (0..3) of the last data octet |
| byte_cnt | input | 14 | Octets in the frame that just ended |
| hold | output | 1 | High while the next frame must not start |

## Verification
The assertions assume that a frame end is strobed only while hold is low and that the mode bit does not change while hold is high. The checks on the configured ratio also assume the setting is stable across the cycle where hold falls. The stimulus respects all of this: each frame is sent only after hold has been seen low, and mode and setting changes are applied between frames. Within that envelope, the sweeps cover every LAN setting from 0 to 127 plus the 10-bit extreme against all four end lanes. They also cover WAN settings from 0 to 20 and 1023 against scattered octet counts, with the bench tracking the deficit and the carry arithmetically.

// File: rtl/ipg_pkg.sv
package ipg_pkg;

  typedef enum logic {
    MODE_LAN = 1'b0,
    MODE_WAN = 1'b1
  } ipg_mode_e;

endpackage

// File: rtl/ipg_cfg_reg.sv
module ipg_cfg_reg #(
  parameter int LANES    = 4,
  parameter int CFG_W    = 10,
  parameter int LAN_MIN  = 8,
  parameter int LAN_MAX  = 100,
  parameter int GAP_RST  = 12,
  parameter int WAN_MIN  = 4,
  parameter int WAN_MAX  = 15,
  parameter int WAN_UNIT = 8,
  localparam int LAN_W   = $clog2(LAN_MAX + 1),
  localparam int RAT_W   = $clog2((WAN_MAX + 1) * WAN_UNIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_gap,
  output logic [LAN_W-1:0] lan_gap,
  output logic [RAT_W-1:0] wan_ratio
);

  function automatic logic [LAN_W-1:0] lan_fn(input logic [CFG_W-1:0] v);
    int t;
    t = int'(v);
    if (t < LAN_MIN) t = LAN_MIN;
    else if (t > LAN_MAX) t = LAN_MAX;
    t = t - (t % LANES);
    return LAN_W'(t);
  endfunction

  function automatic logic [RAT_W-1:0] wan_fn(input logic [CFG_W-1:0] v);
    int s;
    s = int'(v);
    if (s < WAN_MIN) s = WAN_MIN;
    else if (s > WAN_MAX) s = WAN_MAX;
    return RAT_W'((s + 1) * WAN_UNIT);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      lan_gap   <= lan_fn(CFG_W'(GAP_RST));
      wan_ratio <= wan_fn(CFG_W'(GAP_RST));
    end else if (cfg_we) begin
      lan_gap   <= lan_fn(cfg_gap);
      wan_ratio <= wan_fn(cfg_gap);
    end
  end

  AST_LAN_GAP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (int'(lan_gap) >= LAN_MIN) && (int'(lan_gap) <= LAN_MAX) && (int'(lan_gap) % LANES == 0)); // R3
  AST_WAN_RATIO_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (int'(wan_ratio) >= (WAN_MIN + 1) * WAN_UNIT) && (int'(wan_ratio) <= (WAN_MAX + 1) * WAN_UNIT)); // R6
  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(lan_gap) && $stable(wan_ratio)); // R2

endmodule

// File: rtl/ipg_lan_dic.sv
module ipg_lan_dic #(
  parameter int LANES   = 4,
  parameter int LAN_MAX = 100,
  localparam int LANE_W = $clog2(LANES),
  localparam int DEF_W  = $clog2(LANES),
  localparam int LAN_W  = $clog2(LAN_MAX + 1),
  localparam int COL_W  = $clog2(LAN_MAX / LANES + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fe,
  input  logic [LANE_W-1:0] end_lane,
  input  logic [LAN_W-1:0]  lan_gap,
  output logic              hold
);

  logic [DEF_W-1:0] deficit_q;
  logic [COL_W-1:0] cols_q;
  logic             hold_q;
  logic [COL_W-1:0] k_c;
  logic [DEF_W-1:0] dn_c;
  int need_i, n_i, r_i, sum_i;

  // Idle octets still owed after the tail lanes of the end column,
  // split into whole columns and a remainder absorbed by the deficit.
  always_comb begin
    need_i = int'(lan_gap) - (LANES - 1 - int'(end_lane));
    n_i    = need_i / LANES;
    r_i    = need_i % LANES;
    sum_i  = int'(deficit_q) + r_i;
    if (sum_i <= LANES - 1) begin
      k_c  = COL_W'(n_i);
      dn_c = DEF_W'(sum_i);
    end else begin
      k_c  = COL_W'(n_i + 1);
      dn_c = DEF_W'(sum_i - LANES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      deficit_q <= '0;
      cols_q    <= '0;
      hold_q    <= 1'b0;
    end else if (en && fe) begin
      deficit_q <= dn_c;
      cols_q    <= k_c;
      hold_q    <= (k_c != '0);
    end else if (hold_q) begin
      cols_q    <= cols_q - 1'b1;
      hold_q    <= (cols_q > COL_W'(1));
    end
  end

  assign hold = hold_q;

  AST_LAN_HOLD_START: assert property (@(posedge clk) disable iff (rst)
    en && fe |=> hold); // R8
  AST_LAN_DEFICIT_STEADY: assert property (@(posedge clk) disable iff (rst)
    !(en && fe) |=> $stable(deficit_q)); // R5
  AST_LAN_COLS_DRAIN: assert property (@(posedge clk) disable iff (rst)
    hold && !fe |=> int'(cols_q) == int'($past(cols_q)) - 1); // R8

endmodule

// File: rtl/ipg_wan_stretch.sv
module ipg_wan_stretch #(
  parameter int BCNT_W  = 14,
  parameter int RAT_W   = 8,
  parameter int LANES   = 4,
  localparam int ACC_W  = BCNT_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fe,
  input  logic [BCNT_W-1:0] byte_cnt,
  input  logic [RAT_W-1:0]  ratio,
  output logic              hold
);

  logic [ACC_W-1:0] acc_q;
  logic             hold_q;
  logic [ACC_W-1:0] tot_c;
  logic [ACC_W-1:0] step_c;
  int r_i, a_i, s_i;

  // One idle column retires LANES owed octets, i.e. LANES ratios of
  // octets. The last partial column reduces the carry to below one ratio
  // with a short subtract chain instead of a divider.
  always_comb begin
    r_i   = int'(ratio);
    a_i   = int'(acc_q);
    tot_c = ACC_W'(a_i + int'(byte_cnt));
    if (a_i >= LANES * r_i) begin
      s_i = a_i - LANES * r_i;
    end else begin
      s_i = a_i;
      for (int j = 0; j < LANES - 1; j++) begin
        if (s_i >= r_i) s_i = s_i - r_i;
      end
    end
    step_c = ACC_W'(s_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      hold_q <= 1'b0;
    end else if (en && fe) begin
      acc_q  <= tot_c;
      hold_q <= (int'(tot_c) >= r_i);
    end else if (hold_q) begin
      acc_q  <= step_c;
      hold_q <= (int'(step_c) >= r_i);
    end
  end

  assign hold = hold_q;

  AST_WAN_CARRY_BELOW_RATIO: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) && $stable(ratio) |-> acc_q < ACC_W'(ratio)); // R7
  AST_WAN_CARRY_GROWS: assert property (@(posedge clk) disable iff (rst)
    en && fe && !hold |=> acc_q >= ACC_W'($past(byte_cnt))); // R7
  AST_WAN_HOLD_DECREASES: assert property (@(posedge clk) disable iff (rst)
    hold && !fe |=> acc_q < $past(acc_q)); // R7

endmodule

// File: rtl/ipg_gap_ctrl.sv
module ipg_gap_ctrl #(
  parameter int LANES    = 4,
  parameter int CFG_W    = 10,
  parameter int BCNT_W   = 14,
  parameter int LAN_MIN  = 8,
  parameter int LAN_MAX  = 100,
  parameter int GAP_RST  = 12,
  parameter int WAN_MIN  = 4,
  parameter int WAN_MAX  = 15,
  parameter int WAN_UNIT = 8,
  localparam int LANE_W  = $clog2(LANES),
  localparam int LAN_W   = $clog2(LAN_MAX + 1),
  localparam int RAT_W   = $clog2((WAN_MAX + 1) * WAN_UNIT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_gap,
  input  logic              wan_mode,
  input  logic              frame_end,
  input  logic [LANE_W-1:0] end_lane,
  input  logic [BCNT_W-1:0] byte_cnt,
  output logic              hold
);
  import ipg_pkg::*;

  logic [LAN_W-1:0] lan_gap;
  logic [RAT_W-1:0] wan_ratio;
  logic             lan_hold;
  logic             wan_hold;
  ipg_mode_e        mode_s;

  assign mode_s = ipg_mode_e'(wan_mode);

  ipg_cfg_reg #(
    .LANES(LANES), .CFG_W(CFG_W), .LAN_MIN(LAN_MIN), .LAN_MAX(LAN_MAX),
    .GAP_RST(GAP_RST), .WAN_MIN(WAN_MIN), .WAN_MAX(WAN_MAX), .WAN_UNIT(WAN_UNIT)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_gap(cfg_gap),
    .lan_gap(lan_gap), .wan_ratio(wan_ratio)
  );

  ipg_lan_dic #(.LANES(LANES), .LAN_MAX(LAN_MAX)) u_lan (
    .clk(clk), .rst(rst), .en(mode_s == MODE_LAN), .fe(frame_end),
    .end_lane(end_lane), .lan_gap(lan_gap), .hold(lan_hold)
  );

  ipg_wan_stretch #(.BCNT_W(BCNT_W), .RAT_W(RAT_W), .LANES(LANES)) u_wan (
    .clk(clk), .rst(rst), .en(mode_s == MODE_WAN), .fe(frame_end),
    .byte_cnt(byte_cnt), .ratio(wan_ratio), .hold(wan_hold)
  );

  assign hold = lan_hold | wan_hold;

  AST_HOLD_NEEDS_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(frame_end)); // R8
  AST_SINGLE_ENGINE: assert property (@(posedge clk) disable iff (rst)
    !(lan_hold && wan_hold)); // R8
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> !hold); // R1

endmodule

// File: tb/ipg_gap_ctrl_tb.sv
module ipg_gap_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_gap = '0;
  logic        wan_mode = 1'b0;
  logic        frame_end = 1'b0;
  logic [1:0]  end_lane = '0;
  logic [13:0] byte_cnt = '0;
  logic        hold;

  int n_chk = 0;
  int n_bad = 0;
  int cur_gap = 12;
  int m_def = 0;
  int m_acc = 0;

  always #2 clk = ~clk;

  ipg_gap_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_gap(cfg_gap),
    .wan_mode(wan_mode), .frame_end(frame_end), .end_lane(end_lane),
    .byte_cnt(byte_cnt), .hold(hold)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (gap %0d)", tag, act, exp, cur_gap);
    end
  endtask

  function automatic int lan_eff(input int raw);
    int g;
    g = raw < 8 ? 8 : (raw > 100 ? 100 : raw);
    return g - (g % 4);
  endfunction

  function automatic int wan_q(input int raw);
    int s;
    s = raw < 4 ? 4 : (raw > 15 ? 15 : raw);
    return (s + 1) * 8;
  endfunction

  function automatic int lan_expect(input int lane);
    int need, n, r, k;
    need = lan_eff(cur_gap) - (3 - lane);
    n = need / 4;
    r = need % 4;
    if (m_def + r <= 3) begin k = n; m_def = m_def + r; end
    else begin k = n + 1; m_def = m_def + r - 4; end
    return k;
  endfunction

  function automatic int wan_expect(input int bytes);
    int t, q;
    t = m_acc + bytes;
    q = t / wan_q(cur_gap);
    m_acc = t % wan_q(cur_gap);
    return (q + 3) / 4;
  endfunction

  task automatic write_gap(input int v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_gap = 10'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_gap = v;
  endtask

  task automatic send(input int lane, input int bytes, output int cols);
    int guard;
    @(negedge clk);
    frame_end = 1'b1;
    end_lane = 2'(lane);
    byte_cnt = 14'(bytes);
    @(negedge clk);
    frame_end = 1'b0;
    cols = 0;
    guard = 0;
    while (hold && guard < 5000) begin
      cols++;
      guard++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k, tot, nfr, b;
    string tag;
    repeat (3) @(negedge clk);
    check("R1 hold in reset", int'(hold), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 hold after reset", int'(hold), 0);

    // R1: reset gap 12 and zero deficit, lane 0 -> 2 columns
    send(0, 64, k);
    check("R1 reset gap/deficit", k, lan_expect(0));
    send(3, 64, k);
    check("R4 lane3", k, lan_expect(3));

    // R2: cfg_gap ignored without cfg_we
    cfg_gap = 10'd40;
    repeat (2) @(negedge clk);
    send(3, 64, k);
    check("R2 no load without we", k, lan_expect(3));

    // R8: no hold without frame end
    begin
      int seen = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (hold) seen = 1;
      end
      check("R8 idle stays low", seen, 0);
    end

    // R7/R1: WAN carry starts at zero, ratio for 12 is 104
    wan_mode = 1'b1;
    send(1, 103, k);
    check("R7 carry below ratio", k, wan_expect(103));
    send(1, 1, k);
    check("R1 wan carry completes ratio", k, wan_expect(1));

    // LAN sweep
    wan_mode = 1'b0;
    for (int g = 0; g < 130; g++) begin
      write_gap(g == 128 ? 1023 : (g == 129 ? 1000 : g));
      tag = (cur_gap < 8 || cur_gap > 100 || cur_gap % 4 != 0) ? "R3 lan clamp" : "R4 lan cols";
      for (int f = 0; f < 8; f++) begin
        send((f * 3 + g) % 4, 64, k);
        check(tag, k, lan_expect((f * 3 + g) % 4));
      end
    end
    check("R2 10-bit load", lan_eff(cur_gap), 100);

    // R5: long-run average
    write_gap(12);
    tot = 0;
    nfr = 0;
    for (int f = 0; f < 400; f++) begin
      send((f * 7) % 4, 64, k);
      check("R5 deficit step", k, lan_expect((f * 7) % 4));
      tot += (3 - (f * 7) % 4) + 4 * k;
      nfr++;
    end
    check("R5 average gap", int'(tot - 12 * nfr <= 3 && tot - 12 * nfr >= -3), 1);

    // WAN sweep
    wan_mode = 1'b1;
    for (int g = 0; g < 22; g++) begin
      write_gap(g == 21 ? 1023 : g);
      tag = (cur_gap < 4 || cur_gap > 15) ? "R6 wan clamp" : "R7 wan cols";
      for (int f = 0; f < 12; f++) begin
        b = (f * 1237 + g * 311 + 17) % 16384;
        send(f % 4, b, k);
        check(tag, k, wan_expect(b));
      end
    end

    // R8: exact timing on one frame
    write_gap(15);
    send(2, 16383, k);
    check("R8 hold length", k, wan_expect(16383));
    check("R8 hold low after", int'(hold), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule